// File: doc/BRIEF.md
# XOR-feedback random shift register

This block is an eight-stage pseudo-random bit generator meant to drive gate signals and stepped control voltages. Each time its step input goes from low to high, the register moves every stage one place towards the last stage, drops whatever the last stage held, and writes a fresh bit into stage 0. That fresh bit is the exclusive-or of stages 4, 5 and 7, an external data bit and a seed button level. If the register is all zeros and the data bit and seed are low, it stays at zero. Pressing the seed is how it leaves that state after reset.

The eight stage bits leave the block directly as gate outputs. Three 4-bit codes are also taken from windows of the register that start two stages apart, at stages 0, 2 and 4. Each code feeds a small DAC outside the block. Because the windows overlap, a pattern seen on the low code shows up on the middle code two steps later and on the high code two steps after that. Thresholding, conversion and level scaling happen outside the block. All inputs are synchronous to the system clock.

The block carries no data stream with flow control. Its inputs are plain control levels, and its outputs are held levels that a consumer may sample at any time. The register never stalls, so there is no back-pressure to honour.

Top module: `xfb_shift_reg`

## Requirements
- R1: A synchronous reset clears all eight stages. While reset is held and on the first cycle after it, every gate and every code reads zero.
- R2: The register advances exactly once per low-to-high transition of `step_i`. The transition is seen at the clock edge where `step_i` is first sampled high after being sampled low. On every other cycle, including cycles where `step_i` stays high, all outputs hold. After reset, `step_i` must be seen low before a high can advance the register.
- R3: On an advance, stage k (k = 1..7) takes the previous value of stage k-1, and the previous value of stage 7 is discarded.
- R4: On an advance, stage 0 takes stage7 XOR stage5 XOR stage4 XOR `seed_i` XOR `data_i`, using the stage values from before the advance and the inputs sampled at that edge.
- R5: `gate_o[k]` presents stage k for every k from 0 to 7.
- R6: `code_lo_o` is stages 0..3, `code_mid_o` is stages 2..5 and `code_hi_o` is stages 4..7. In each code the lowest-numbered stage is bit 0.
- R7: The value of `code_lo_o` appears on `code_mid_o` after two further advances, and on `code_hi_o` after four.
- R8: With all stages zero and `data_i` and `seed_i` both low, an advance leaves the register at zero.
- R9: With all stages zero, an advance with `seed_i` high and `data_i` low sets stage 0 to one and leaves the other stages at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Step level; a rising transition advances the register |
| data_i | input | 1 | External data bit mixed into the new bit |
| seed_i | input | 1 | Debounced seed button level mixed into the new bit |
| gate_o | output | 8 | Stage bits, bit k is stage k |
| code_lo_o | output | 4 | Code from stages 0..3 |
| code_mid_o | output | 4 | Code from stages 2..5 |
| code_hi_o | output | 4 | Code from stages 4..7 |

## Verification
On every cycle, the assertions check the one-place move on an advance, the mixing of the new bit, the holding of outputs between transitions, the mapping from stages to the three codes, and the zero lock. The bench's scenarios show the behaviour that spans several advances. This covers the low-code value reaching the middle and high codes after two and four steps, and leaving the lock with the seed. It also covers long random runs that mix data, seed and irregular step timing, checked against a bench-side model.

// File: rtl/xfb_pkg.sv
package xfb_pkg;
  localparam int STAGES_DEF = 8;
  localparam int WIN_DEF    = 4;
  localparam int STRIDE_DEF = 2;
  localparam int NWIN_DEF   = 3;
  // stage mask of internal taps mixed into the new bit (stages 7, 5, 4)
  localparam logic [STAGES_DEF-1:0] TAPS_DEF = 8'b1011_0000;
endpackage

// File: rtl/xfb_edge_detect.sv
module xfb_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  // reset to high so that a level held high through reset is not an edge
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b1;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q & ~rst;
endmodule

// File: rtl/xfb_feedback.sv
module xfb_feedback #(
  parameter int STAGES = 8,
  parameter logic [STAGES-1:0] TAPS = 8'b1011_0000
) (
  input  logic [STAGES-1:0] st_i,
  input  logic              data_i,
  input  logic              seed_i,
  output logic              bit_o
);
  logic tap_par;

  always_comb begin
    tap_par = ^(st_i & TAPS);
    bit_o   = tap_par ^ seed_i ^ data_i;
  end
endmodule

// File: rtl/xfb_stage_chain.sv
module xfb_stage_chain #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              new_i,
  output logic [STAGES-1:0] st_o
);
  logic [STAGES-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else if (adv_i) st_q[0] <= new_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st_q[k] <= 1'b0;
      else if (adv_i) st_q[k] <= st_q[k-1];
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/xfb_windows.sv
module xfb_windows #(
  parameter int STAGES = 8,
  parameter int WIN    = 4,
  parameter int STRIDE = 2,
  parameter int NWIN   = 3
) (
  input  logic [STAGES-1:0]    st_i,
  output logic [NWIN*WIN-1:0]  codes_o
);
  localparam int SPAN = (NWIN - 1) * STRIDE + WIN;

  if (SPAN > STAGES) begin : g_bad
    initial $display("xfb_windows: windows exceed the register");
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign codes_o[w*WIN +: WIN] = st_i[w*STRIDE +: WIN];
  end
endmodule

// File: rtl/xfb_shift_reg.sv
module xfb_shift_reg
  import xfb_pkg::*;
#(
  parameter int STAGES = STAGES_DEF,
  parameter int WIN    = WIN_DEF,
  parameter int STRIDE = STRIDE_DEF,
  parameter logic [STAGES-1:0] TAPS = TAPS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              data_i,
  input  logic              seed_i,
  output logic [STAGES-1:0] gate_o,
  output logic [WIN-1:0]    code_lo_o,
  output logic [WIN-1:0]    code_mid_o,
  output logic [WIN-1:0]    code_hi_o
);
  localparam int NWIN = 3;

  logic              adv;
  logic              nbit;
  logic [STAGES-1:0] st;
  logic [NWIN*WIN-1:0] codes;

  xfb_edge_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (step_i),
    .rise_o(adv)
  );

  xfb_feedback #(.STAGES(STAGES), .TAPS(TAPS)) u_fb (
    .st_i  (st),
    .data_i(data_i),
    .seed_i(seed_i),
    .bit_o (nbit)
  );

  xfb_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .adv_i(adv),
    .new_i(nbit),
    .st_o (st)
  );

  xfb_windows #(.STAGES(STAGES), .WIN(WIN), .STRIDE(STRIDE), .NWIN(NWIN)) u_win (
    .st_i   (st),
    .codes_o(codes)
  );

  assign gate_o     = st;
  assign code_lo_o  = codes[0*WIN +: WIN];
  assign code_mid_o = codes[1*WIN +: WIN];
  assign code_hi_o  = codes[2*WIN +: WIN];
endmodule

// File: rtl/xfb_shift_reg_chk.sv
module xfb_shift_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_i,
  input logic       data_i,
  input logic       seed_i,
  input logic [7:0] gate_o,
  input logic [3:0] code_lo_o,
  input logic [3:0] code_mid_o,
  input logic [3:0] code_hi_o
);
  logic prev_step;
  logic rst_q;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) prev_step <= 1'b1;
    else     prev_step <= step_i;
    rst_q <= rst;
  end

  assign rise = step_i && !prev_step;

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (gate_o == 8'h00 && code_lo_o == 4'h0 && code_mid_o == 4'h0 && code_hi_o == 4'h0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(gate_o));

  a_r3_move: assert property (@(posedge clk) disable iff (rst)
    rise |=> gate_o[7:1] == $past(gate_o[6:0]));

  a_r4_newbit: assert property (@(posedge clk) disable iff (rst)
    rise |=> gate_o[0] == $past(gate_o[7] ^ gate_o[5] ^ gate_o[4] ^ seed_i ^ data_i));

  a_r6_codes: assert property (@(posedge clk) disable iff (rst)
    code_lo_o == gate_o[3:0] && code_mid_o == gate_o[5:2] && code_hi_o == gate_o[7:4]);

  a_r8_lock: assert property (@(posedge clk) disable iff (rst)
    (gate_o == 8'h00 && !seed_i && !data_i) |=> gate_o == 8'h00);
endmodule

bind xfb_shift_reg xfb_shift_reg_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .step_i    (step_i),
  .data_i    (data_i),
  .seed_i    (seed_i),
  .gate_o    (gate_o),
  .code_lo_o (code_lo_o),
  .code_mid_o(code_mid_o),
  .code_hi_o (code_hi_o)
);

// File: tb/test_xfb_shift_reg.sv
module test_xfb_shift_reg;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_i = 1'b0;
  logic       data_i = 1'b0;
  logic       seed_i = 1'b0;
  logic [7:0] gate_o;
  logic [3:0] code_lo_o, code_mid_o, code_hi_o;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] model = 8'h00;
  logic       prev_lvl = 1'b1;
  bit         done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  xfb_shift_reg i_xfb_shift_reg (
    .clk(clk), .rst(rst), .step_i(step_i), .data_i(data_i), .seed_i(seed_i),
    .gate_o(gate_o), .code_lo_o(code_lo_o), .code_mid_o(code_mid_o), .code_hi_o(code_hi_o)
  );

  function automatic logic mix(input logic [7:0] s, input logic d, input logic sd);
    return s[7] ^ s[5] ^ s[4] ^ sd ^ d;
  endfunction

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp({req, " R5 gates"}, gate_o, model);
    cmp({req, " R6 lo"},  {4'h0, code_lo_o},  {4'h0, model[3:0]});
    cmp({req, " R6 mid"}, {4'h0, code_mid_o}, {4'h0, model[5:2]});
    cmp({req, " R6 hi"},  {4'h0, code_hi_o},  {4'h0, model[7:4]});
  endtask

  // drive one cycle, update model, sample a quarter period after the edge
  task automatic cyc(input logic lvl, input logic d, input logic sd);
    @(negedge clk);
    step_i = lvl; data_i = d; seed_i = sd;
    if (lvl && !prev_lvl) model = {model[6:0], mix(model, d, sd)};
    prev_lvl = lvl;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic advance(input logic d, input logic sd);
    cyc(1'b0, d, sd);
    cyc(1'b1, d, sd);
  endtask

  initial begin
    #(PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [3:0] lo_seen;
    void'($urandom(32'd20240611));
    // R1 reset state, step held high through reset
    step_i = 1'b1;
    repeat (4) @(negedge clk);
    #(PERIOD/4);
    check_all("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    model = 8'h00; prev_lvl = 1'b1;
    cyc(1'b1, 1'b0, 1'b1);
    check_all("R1 first cycle after reset, R2 no edge");
    // R8 lock-up with data and seed low
    for (int i = 0; i < 6; i++) advance(1'b0, 1'b0);
    cmp("R8 zero stays zero", gate_o, 8'h00);
    // R9 seed leaves lock-up
    advance(1'b0, 1'b1);
    cmp("R9 seed sets stage 0", gate_o, 8'h01);
    // R3 single one walks down, R2 level held high makes no more shifts
    for (int i = 0; i < 3; i++) advance(1'b0, 1'b0);
    cmp("R3 walk", gate_o, 8'h08);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1);
    cmp("R2 held high no shift", gate_o, 8'h08);
    // R4 data bit alone
    advance(1'b1, 1'b0);
    cmp("R4 data mixes in", gate_o, 8'h11);
    // R4 taps: with stage 4 set, data and seed cancel tap
    advance(1'b1, 1'b1);
    cmp("R4 tap4 only", gate_o, 8'h23);
    // R3 stage 7 discarded
    for (int i = 0; i < 8; i++) advance(1'b0, 1'b0);
    check_all("R3 R4 tap run");
    // R7 window propagation
    lo_seen = code_lo_o;
    advance(1'b0, 1'b0);
    advance(1'b0, 1'b0);
    cmp("R7 lo to mid", {4'h0, code_mid_o}, {4'h0, lo_seen});
    advance(1'b1, 1'b0);
    advance(1'b0, 1'b1);
    cmp("R7 lo to hi", {4'h0, code_hi_o}, {4'h0, lo_seen});
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] r;
      r = 3'($urandom());
      cyc(r[0], r[1], r[2]);
      check_all("R2 R3 R4 random");
    end
    // R1 mid-run reset
    @(negedge clk);
    rst = 1'b1; step_i = 1'b0;
    @(posedge clk);
    #(PERIOD/4);
    model = 8'h00; prev_lvl = 1'b1;
    check_all("R1 reset mid-run");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule